// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments into a descriptor table for a bus-master disk DMA engine. Each segment is a 32-bit bus address and a byte length, and arrives on a valid/ready stream. The block writes two-word descriptors, one 32-bit word per cycle, into a descriptor RAM through a write port with a word index. It cuts each segment so that no descriptor crosses a 64 KB address boundary. A chunk that would fill a whole 64 KB window cannot be encoded safely, so it becomes two 32 KB descriptors. When the list ends, the block sets the end-of-table flag on the last descriptor.

When the list is finished, a one-cycle done pulse reports the number of descriptors and an error code. An error always reports a count of zero. The caller then moves the transfer to programmed I/O. Errors are: the table fills up, the list yields no descriptor, or a segment has an odd length. Segment addresses are assumed to be 16-bit aligned.

Back-pressure on the segment stream: `seg_ready` is high only while the block is waiting for a segment. It falls as soon as a segment is taken and stays low while that segment's descriptors are written and during the done cycle. A segment moves only on a clock edge where both `seg_valid` and `seg_ready` are high. The source must hold its payload stable until then.

Top module: `prd_table_builder`

## Requirements
- R1: Descriptor k occupies word index 2k (the buffer address) and word index 2k+1 (the count word). The count word holds the byte count in bits 15:0 and zeros in bits 30:16. Words are written one per cycle, each address word immediately followed by its count word.
- R2: The bytes in one descriptor equal the smaller of two values: the remaining segment length, and 0x10000 minus bits 15:0 of the current address. The next descriptor starts at the first byte not yet covered.
- R3: A chunk that would be exactly 0x10000 bytes is written as two descriptors of 0x8000 bytes each. The first is at the chunk address and the second at that address plus 0x8000.
- R4: When the list completes without error, bit 31 of the final descriptor's count word is set. No other count word has bit 31 set.
- R5: On successful completion, `done` is high for exactly one cycle. At that cycle `done_count` is the number of descriptors and `done_err` is 0 (no error).
- R6: If a descriptor would be written while CAP descriptors are already stored, the block writes nothing more for the list. This includes the second half of a 32 KB pair. It reports `done_err` = 1 and `done_count` = 0. A list that exactly fills the table succeeds.
- R7: A list that produces no descriptor reports `done_err` = 2 and `done_count` = 0, with no RAM writes.
- R8: A segment with an odd length ends descriptor generation for the list. The block reports `done_err` = 3 and `done_count` = 0. The first error found in a list is the one reported.
- R9: `seg_ready` is low while descriptors are written and during the done cycle. After an error, the remaining segments are accepted and discarded up to the one flagged last, with no RAM writes.
- R10: A zero-length segment produces no descriptor and does not affect its neighbours.
- R11: After reset, `seg_ready` is high and `done` and `tbl_we` are low. The block is ready for a new list in the cycle after each done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment on the inputs is valid |
| seg_ready | output | 1 | Block accepts a segment this cycle |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Segment is the last of the list |
| tbl_we | output | 1 | Descriptor RAM word write strobe |
| tbl_idx | output | $clog2(CAP)+1 | Descriptor RAM word index |
| tbl_wdata | output | 32 | Descriptor RAM word data |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | $clog2(CAP+1) | Descriptors in the table (0 on error) |
| done_err | output | 2 | 0 none, 1 table full, 2 empty, 3 odd length |

## Verification
The hardest case to reach is a table that fills up on the second half of a 32 KB pair: 255 descriptors must already be stored when a 64 KB-aligned chunk arrives. The stimulus gets there with one segment of 0x7F8000 bytes from address zero, which yields 255 full 32 KB descriptors. A second segment of 0x10000 bytes at a 64 KB-aligned address then follows. The run checks the error code, the zero count and the exact number of RAM writes. A list that exactly fills the table, and a list that overflows by a single 2-byte descriptor, bracket the capacity limit.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_OVERFLOW = 2'd1,
    ERR_EMPTY    = 2'd2,
    ERR_ODD      = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CNT,
    ST_DRAIN,
    ST_FIN
  } state_e;

  localparam logic [16:0] WINDOW_BYTES = 17'h10000;
  localparam logic [16:0] HALF_WINDOW  = 17'h08000;

endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc import prd_pkg::*; #(
  parameter int LEN_W = 32
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic [16:0]      chunk
);
  localparam int CMP_W = (LEN_W > 17) ? LEN_W : 17;

  logic [16:0]      room;
  logic [CMP_W-1:0] room_x;
  logic [CMP_W-1:0] len_x;
  logic [16:0]      raw;

  always_comb begin
    // bytes left before the next 64 KB boundary
    room   = WINDOW_BYTES - {1'b0, addr_lo};
    room_x = CMP_W'(room);
    len_x  = CMP_W'(len);
    raw    = (len_x < room_x) ? 17'(len_x) : room;
    // a full window cannot be encoded; take half, the rest follows next
    chunk  = (raw == WINDOW_BYTES) ? HALF_WINDOW : raw;
  end
endmodule

// File: rtl/prd_word_fmt.sv
module prd_word_fmt (
  input  logic        is_cnt,
  input  logic        mark,
  input  logic [31:0] addr,
  input  logic [15:0] bytes,
  output logic [31:0] word
);
  always_comb begin
    if (is_cnt) word = {mark, 15'd0, bytes};
    else        word = addr;
  end
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder import prd_pkg::*; #(
  parameter int CAP   = 256,
  parameter int LEN_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_valid,
  output logic                       seg_ready,
  input  logic [31:0]                seg_addr,
  input  logic [LEN_W-1:0]           seg_len,
  input  logic                       seg_last,
  output logic                       tbl_we,
  output logic [$clog2(CAP):0]       tbl_idx,
  output logic [31:0]                tbl_wdata,
  output logic                       done,
  output logic [$clog2(CAP+1)-1:0]   done_count,
  output logic [1:0]                 done_err
);
  localparam int ENT_W = $clog2(CAP);
  localparam int CNT_W = $clog2(CAP+1);

  state_e           st;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] cur_len;
  logic             cur_last;
  logic [CNT_W-1:0] n_ent;
  err_e             err_q;
  logic [15:0]      last_bytes;

  logic [16:0]      chunk;
  logic             tbl_full;
  logic             seg_spent;
  logic [CNT_W-1:0] n_prev;
  err_e             final_err;
  logic             fmt_cnt;
  logic             fmt_mark;
  logic [15:0]      fmt_bytes;

  prd_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
    .addr_lo (cur_addr[15:0]),
    .len     (cur_len),
    .chunk   (chunk)
  );

  prd_word_fmt u_fmt (
    .is_cnt (fmt_cnt),
    .mark   (fmt_mark),
    .addr   (cur_addr),
    .bytes  (fmt_bytes),
    .word   (tbl_wdata)
  );

  always_comb begin
    tbl_full  = (n_ent == CNT_W'(CAP));
    seg_spent = (LEN_W'(chunk) == cur_len);
    n_prev    = n_ent - 1'b1;
    if (err_q != ERR_NONE)      final_err = err_q;
    else if (n_ent == '0)       final_err = ERR_EMPTY;
    else                        final_err = ERR_NONE;
  end

  always_comb begin
    seg_ready  = (st == ST_IDLE) || (st == ST_DRAIN);
    tbl_we     = 1'b0;
    tbl_idx    = '0;
    fmt_cnt    = 1'b0;
    fmt_mark   = 1'b0;
    fmt_bytes  = chunk[15:0];
    done       = 1'b0;
    done_count = '0;
    done_err   = ERR_NONE;
    unique case (st)
      ST_ADDR: begin
        tbl_we  = !tbl_full;
        tbl_idx = {n_ent[ENT_W-1:0], 1'b0};
      end
      ST_CNT: begin
        tbl_we  = 1'b1;
        tbl_idx = {n_ent[ENT_W-1:0], 1'b1};
        fmt_cnt = 1'b1;
      end
      ST_FIN: begin
        // rewrite the final count word with the end-of-table flag
        tbl_we     = (final_err == ERR_NONE);
        tbl_idx    = {n_prev[ENT_W-1:0], 1'b1};
        fmt_cnt    = 1'b1;
        fmt_mark   = 1'b1;
        fmt_bytes  = last_bytes;
        done       = 1'b1;
        done_err   = final_err;
        done_count = (final_err == ERR_NONE) ? n_ent : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      cur_len    <= '0;
      cur_last   <= 1'b0;
      n_ent      <= '0;
      err_q      <= ERR_NONE;
      last_bytes <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (seg_valid) begin
            cur_addr <= seg_addr;
            cur_len  <= seg_len;
            cur_last <= seg_last;
            if (seg_len[0]) begin
              err_q <= ERR_ODD;
              st    <= seg_last ? ST_FIN : ST_DRAIN;
            end else if (seg_len == '0) begin
              st    <= seg_last ? ST_FIN : ST_IDLE;
            end else begin
              st    <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (tbl_full) begin
            err_q <= ERR_OVERFLOW;
            st    <= cur_last ? ST_FIN : ST_DRAIN;
          end else begin
            st    <= ST_CNT;
          end
        end
        ST_CNT: begin
          n_ent      <= n_ent + 1'b1;
          last_bytes <= chunk[15:0];
          cur_addr   <= cur_addr + 32'(chunk);
          cur_len    <= cur_len - LEN_W'(chunk);
          if (seg_spent) st <= cur_last ? ST_FIN : ST_IDLE;
          else           st <= ST_ADDR;
        end
        ST_DRAIN: begin
          if (seg_valid && seg_last) st <= ST_FIN;
        end
        ST_FIN: begin
          n_ent <= '0;
          err_q <= ERR_NONE;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_table_builder_chk.sv
module prd_table_builder_chk #(
  parameter int CAP = 256
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     seg_ready,
  input logic                     tbl_we,
  input logic [$clog2(CAP):0]     tbl_idx,
  input logic [31:0]              tbl_wdata,
  input logic                     done,
  input logic [$clog2(CAP+1)-1:0] done_count,
  input logic [1:0]               done_err
);
  AST_COUNT_WORD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_idx[0]) |-> (tbl_wdata[30:16] == 15'd0 && tbl_wdata[15:0] != 16'd0)); // R1

  AST_ADDR_THEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !tbl_idx[0]) |=> (tbl_we && tbl_idx[0])); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_OK_HAS_ENTRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == 2'd0) |-> (done_count != '0)); // R7

  AST_ERR_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err != 2'd0) |-> (done_count == '0 && !tbl_we)); // R6

  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !seg_ready); // R9

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> seg_ready); // R11
endmodule

bind prd_table_builder prd_table_builder_chk #(.CAP(CAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seg_ready  (seg_ready),
  .tbl_we     (tbl_we),
  .tbl_idx    (tbl_idx),
  .tbl_wdata  (tbl_wdata),
  .done       (done),
  .done_count (done_count),
  .done_err   (done_err)
);

// File: tb/prd_table_builder_tb.sv
module prd_table_builder_tb;
  localparam int CAP   = 256;
  localparam int WORDS = 2 * CAP;
  localparam int MAXS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [31:0] seg_addr = '0;
  logic [31:0] seg_len = '0;
  logic seg_last = 1'b0;
  logic tbl_we;
  logic [$clog2(CAP):0] tbl_idx;
  logic [31:0] tbl_wdata;
  logic done;
  logic [$clog2(CAP+1)-1:0] done_count;
  logic [1:0] done_err;

  always #10 clk = ~clk;

  prd_table_builder #(.CAP(CAP), .LEN_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
    .done(done), .done_count(done_count), .done_err(done_err)
  );

  // bench-side descriptor RAM and completion capture
  logic [31:0] ram [WORDS];
  logic clr = 1'b0;
  int   wr_cnt;
  logic got_done;
  int   got_cnt;
  logic [1:0] got_err;

  always @(posedge clk) begin
    if (clr) begin
      wr_cnt   <= 0;
      got_done <= 1'b0;
    end else begin
      if (tbl_we) begin
        ram[tbl_idx] <= tbl_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (done) begin
        got_done <= 1'b1;
        got_cnt  <= int'(done_count);
        got_err  <= done_err;
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail + 1);
      $finish;
    end
  end

  // segment list and independent reference model
  logic [31:0] sa [MAXS];
  logic [31:0] sl [MAXS];
  int ns;
  logic [31:0] exp_w [WORDS];
  int exp_n;
  logic [1:0] exp_e;
  int exp_wr;

  task automatic model();
    int n = 0;
    logic [1:0] e = 2'd0;
    for (int s = 0; s < ns; s++) begin
      longint a = longint'(sa[s]);
      longint l = longint'(sl[s]);
      if (e != 2'd0) continue;
      if (l[0]) begin e = 2'd3; continue; end
      while (l > 0 && e == 2'd0) begin
        longint bc = 64'h10000 - (a & 64'hffff);
        if (bc > l) bc = l;
        if (n >= CAP) begin e = 2'd1; break; end
        if (bc == 64'h10000) begin
          exp_w[2*n] = a[31:0]; exp_w[2*n+1] = 32'h8000; n++;
          if (n >= CAP) begin e = 2'd1; break; end
          exp_w[2*n] = a[31:0] + 32'h8000; exp_w[2*n+1] = 32'h8000; n++;
        end else begin
          exp_w[2*n] = a[31:0]; exp_w[2*n+1] = bc[31:0]; n++;
        end
        a += bc;
        l -= bc;
      end
    end
    exp_wr = 2 * n;
    if (e != 2'd0) n = 0;
    else if (n == 0) e = 2'd2;
    else begin
      exp_w[2*n-1][31] = 1'b1;
      exp_wr = exp_wr + 1;
    end
    exp_n = n;
    exp_e = e;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input logic last);
    @(negedge clk);
    seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!got_done && w < 5000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic start_list();
    model();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_list(input string req);
    wait_done();
    check(got_done, req, "done seen", 32'(got_done), 32'd1);
    check(got_err == exp_e, req, "done_err", 32'(got_err), 32'(exp_e));
    check(got_cnt == exp_n, req, "done_count", 32'(got_cnt), 32'(exp_n));
    check(wr_cnt == exp_wr, req, "RAM write count", 32'(wr_cnt), 32'(exp_wr));
    for (int k = 0; k < 2 * exp_n; k++)
      check(ram[k] === exp_w[k], req, $sformatf("word %0d", k), ram[k], exp_w[k]);
  endtask

  task automatic run_list(input string req);
    start_list();
    for (int s = 0; s < ns; s++) send_seg(sa[s], sl[s], s == ns - 1);
    finish_list(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(seg_ready == 1'b1, "R11", "ready after reset", 32'(seg_ready), 32'd1);
    check(done == 1'b0, "R11", "done after reset", 32'(done), 32'd0);
    check(tbl_we == 1'b0, "R11", "we after reset", 32'(tbl_we), 32'd0);
  endtask

  task automatic t_single();          // R1 R4 R5
    ns = 1; sa[0] = 32'h1000_0100; sl[0] = 32'h200;
    run_list("R5");
  endtask

  task automatic t_cross_backpressure(); // R2 R9
    ns = 1; sa[0] = 32'h0000_F000; sl[0] = 32'h3000;
    start_list();
    @(negedge clk);
    seg_valid = 1'b1; seg_addr = sa[0]; seg_len = sl[0]; seg_last = 1'b1;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
    check(seg_ready == 1'b0, "R9", "ready low while emitting", 32'(seg_ready), 32'd0);
    @(negedge clk);
    check(seg_ready == 1'b0, "R9", "ready low while emitting", 32'(seg_ready), 32'd0);
    finish_list("R2");
  endtask

  task automatic t_full_window();     // R3
    ns = 1; sa[0] = 32'h0002_0000; sl[0] = 32'h1_0000;
    run_list("R3");
  endtask

  task automatic t_multi_zero();      // R10 R4
    ns = 3;
    sa[0] = 32'h0010_0000; sl[0] = 32'h100;
    sa[1] = 32'h0020_0000; sl[1] = 32'h0;
    sa[2] = 32'h0003_FFF0; sl[2] = 32'h20;
    run_list("R10");
    check(ram[1][31] == 1'b0, "R4", "first count word unmarked", ram[1], ram[1] & 32'h7FFF_FFFF);
  endtask

  task automatic t_long_segment();    // R2 R3
    ns = 1; sa[0] = 32'h0004_1000; sl[0] = 32'h3_0000;
    run_list("R2");
  endtask

  task automatic t_exact_capacity();  // R6 boundary: fills the table
    ns = 1; sa[0] = 32'h0; sl[0] = 32'h80_0000;
    run_list("R6");
  endtask

  task automatic t_overflow_tail();   // R6 with drained follower R9
    ns = 2; sa[0] = 32'h0; sl[0] = 32'h80_0002;
    sa[1] = 32'h0100_0000; sl[1] = 32'h40;
    run_list("R6");
  endtask

  task automatic t_overflow_split();  // R6 on the second 32 KB half
    ns = 2; sa[0] = 32'h0; sl[0] = 32'h7F_8000;
    sa[1] = 32'h0100_0000; sl[1] = 32'h1_0000;
    run_list("R6");
  endtask

  task automatic t_empty();           // R7
    ns = 2; sa[0] = 32'h400; sl[0] = 32'h0;
    sa[1] = 32'h800; sl[1] = 32'h0;
    run_list("R7");
  endtask

  task automatic t_odd();             // R8 R9
    ns = 3; sa[0] = 32'h2000; sl[0] = 32'h101;
    sa[1] = 32'h3000; sl[1] = 32'h80;
    sa[2] = 32'h4000; sl[2] = 32'h80;
    run_list("R8");
  endtask

  task automatic t_odd_after_entries(); // R8 first error wins
    ns = 2; sa[0] = 32'h5000; sl[0] = 32'h40;
    sa[1] = 32'h6000; sl[1] = 32'h33;
    run_list("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_cross_backpressure();
    t_full_window();
    t_multi_zero();
    t_long_segment();
    t_exact_capacity();
    t_overflow_tail();
    t_single();
    t_overflow_split();
    t_empty();
    t_odd();
    t_odd_after_entries();
    t_single();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule